// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block keeps a small table of chip-select windows that place SDRAM ranks inside the 32-bit physical address map. Software programs each window as a base/size register pair through a 32-bit register port. A window takes part in decoding only when its enable bit is set and none of the address-extension bits above 4 GB are set in its base register. Such a window is called usable.

Address lookups are issued on a request port. A small scan engine walks the windows from index 0 upward, one window per cycle, and reports whether the address hit a window, which chip select it hit, and the attribute code that other bus masters attach to accesses aimed at that rank. The block also outputs the number of usable chip selects. A readout port lists the usable windows packed in ascending index order, so a client can walk the live DRAM map without skipping holes.

The scan engine has three states. `S_IDLE` waits for a request and moves to `S_SCAN` when `lk_req` is seen. `S_SCAN` tests one window per cycle and moves to `S_DONE` after the last index. `S_DONE` presents the result for one cycle and always returns to `S_IDLE`.

Top module: `dcsw_window_map`

## Requirements
- R1: After reset, every window is cleared and disabled. All registers read 0, `active_cnt` is 0, `slot_valid` is low, `lk_ready` is high, and every lookup misses.
- R2: Chip select n has its base register at byte offset 8n and its size register at byte offset 8n+4. Address bits [1:0] are ignored. A write lands on the clock edge where `reg_wr` is high and is visible on `reg_rdata` and on the decode outputs from the next cycle.
- R3: The base register keeps bits 31:24 (address bits 31:24) and bits 3:0 (address-extension bits); its other bits read 0. The size register keeps bits 31:24 (size field, 16 MB units), bits 4:2 (a chip-select tag that is stored and read back without affecting decode) and bit 0 (enable); its other bits read 0.
- R4: A window is usable only when size bit 0 is 1 and base bits 3:0 are all 0.
- R5: `active_cnt` equals the number of usable windows.
- R6: With `rd_slot` = k, the slot outputs describe the k-th usable window in ascending index order. `slot_base` is base[31:24] followed by 24 zero bits. `slot_size` is (size register with bits 23:0 forced to 1) + 1, on 33 bits. `slot_valid` is low when k is not below `active_cnt`.
- R7: The attribute for chip select n has its low NUM_CS bits all 1 except bit n, which is 0. The top bit equals the COHERENT parameter. With the defaults: cs0 gives 0x0E, cs1 0x0D, cs2 0x0B, cs3 0x07.
- R8: An address hits window n when n is usable and address bits 31:24 equal base bits 31:24 at every position where the size field bit is 0. When several windows hit, the lowest index wins. A miss reports `res_hit`=0, `res_cs`=0 and `res_attr`=0.
- R9: A request is accepted on a clock edge where `lk_req` and `lk_ready` are both high. `res_valid` is high for exactly one cycle, NUM_CS cycles after the accepting edge. `lk_ready` stays low from acceptance until the cycle after the result, and requests made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_ready | output | 1 | Scan engine idle, request can be taken |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Lookup hit a usable window |
| res_cs | output | CS_W | Winning chip select |
| res_attr | output | NUM_CS+1 | Attribute of the winning chip select |
| active_cnt | output | CNT_W | Number of usable windows |
| rd_slot | input | CS_W | Index into the packed list of usable windows |
| slot_valid | output | 1 | Selected slot exists |
| slot_cs | output | CS_W | Chip select held in the slot |
| slot_base | output | 32 | Base address of the slot |
| slot_size | output | 33 | Size in bytes of the slot |
| slot_attr | output | NUM_CS+1 | Attribute of the slot |

## Verification
Register readback, `active_cnt` and the slot outputs are combinational on the registered window table. The bench therefore reads them one cycle after a write edge, with a short settle delay after changing `reg_addr` or `rd_slot`. Lookup results are due exactly NUM_CS clock edges after the accepting edge. The driver records the cycle number in each scoreboard entry, and the monitor samples on the falling edge and compares both the arrival cycle and the payload. A request raised while the engine is busy must produce no scoreboard entry, and any `res_valid` that arrives with the queue empty is reported as a failure.

// File: rtl/dcsw_pkg.sv
package dcsw_pkg;

    // One chip-select window as held in the register table.
    typedef struct packed {
        logic [7:0] base_top;   // address bits 31:24
        logic [3:0] base_ext;   // address bits above 4 GB
        logic [7:0] span;       // size field, 16 MB granules
        logic [2:0] cs_tag;     // stored chip-select tag
        logic       en;         // window enable
    } cs_win_t;

    localparam int GRAN_BITS = 24;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCAN,
        S_DONE
    } scan_state_e;

    function automatic logic win_usable(cs_win_t w);
        return w.en && (w.base_ext == 4'd0);
    endfunction

endpackage

// File: rtl/dcsw_regs.sv
module dcsw_regs
    import dcsw_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int REG_AW = $clog2(NUM_CS) + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output cs_win_t [NUM_CS-1:0]   wins
);
    localparam int CS_W = $clog2(NUM_CS);

    cs_win_t [NUM_CS-1:0] win_q;
    logic [CS_W-1:0]      sel_idx;
    logic                 sel_size;

    assign sel_idx  = reg_addr[REG_AW-1:3];
    assign sel_size = reg_addr[2];
    assign wins     = win_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (reg_wr) begin
            for (int i = 0; i < NUM_CS; i++) begin
                if (sel_idx == CS_W'(i)) begin
                    if (sel_size) begin
                        win_q[i].span   <= reg_wdata[31:24];
                        win_q[i].cs_tag <= reg_wdata[4:2];
                        win_q[i].en     <= reg_wdata[0];
                    end else begin
                        win_q[i].base_top <= reg_wdata[31:24];
                        win_q[i].base_ext <= reg_wdata[3:0];
                    end
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel_idx == CS_W'(i)) begin
                if (sel_size)
                    reg_rdata = {win_q[i].span, 19'd0, win_q[i].cs_tag, 1'b0, win_q[i].en};
                else
                    reg_rdata = {win_q[i].base_top, 20'd0, win_q[i].base_ext};
            end
        end
    end

    // R2: a size write to window g sets its enable from data bit 0
    for (genvar g = 0; g < NUM_CS; g++) begin : g_wr_chk
        a_r2_size_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && sel_size && sel_idx == CS_W'(g)) |=> (wins[g].en == $past(reg_wdata[0])));
        a_r2_base_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && !sel_size && sel_idx == CS_W'(g)) |=> (wins[g].base_top == $past(reg_wdata[31:24])));
    end

endmodule

// File: rtl/dcsw_compact.sv
module dcsw_compact
    import dcsw_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter bit COHERENT = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  cs_win_t [NUM_CS-1:0]        wins,
    input  logic [$clog2(NUM_CS)-1:0]   rd_slot,
    output logic [NUM_CS-1:0]           usable_vec,
    output logic [$clog2(NUM_CS+1)-1:0] active_cnt,
    output logic                        slot_valid,
    output logic [$clog2(NUM_CS)-1:0]   slot_cs,
    output logic [31:0]                 slot_base,
    output logic [32:0]                 slot_size,
    output logic [NUM_CS:0]             slot_attr
);
    localparam int CS_W  = $clog2(NUM_CS);
    localparam int CNT_W = $clog2(NUM_CS+1);

    function automatic logic [NUM_CS:0] attr_for(logic [CS_W-1:0] idx);
        logic [NUM_CS:0] a;
        a = {COHERENT, {NUM_CS{1'b1}}};
        a[idx] = 1'b0;
        return a;
    endfunction

    logic [CNT_W-1:0] run_cnt;
    logic [CS_W-1:0]  pick;
    logic             found;

    always_comb begin
        for (int i = 0; i < NUM_CS; i++)
            usable_vec[i] = win_usable(wins[i]);
    end

    // Walk ascending; the rd_slot-th usable window is the one picked.
    always_comb begin
        run_cnt = '0;
        pick    = '0;
        found   = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (usable_vec[i]) begin
                if (run_cnt == CNT_W'(rd_slot)) begin
                    found = 1'b1;
                    pick  = CS_W'(i);
                end
                run_cnt = run_cnt + 1'b1;
            end
        end
    end

    assign active_cnt = run_cnt;
    assign slot_valid = found;
    assign slot_cs    = pick;
    assign slot_base  = found ? {wins[pick].base_top, {GRAN_BITS{1'b0}}} : 32'd0;
    assign slot_size  = found ? ({1'b0, wins[pick].span, {GRAN_BITS{1'b1}}} + 33'd1) : 33'd0;
    assign slot_attr  = found ? attr_for(pick) : '0;

    a_r6_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (CNT_W'(rd_slot) < active_cnt));
    a_r6_slot_is_usable: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (wins[slot_cs].en && wins[slot_cs].base_ext == 4'd0));
    a_r7_slot_attr_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> ($countones(slot_attr[NUM_CS-1:0]) == NUM_CS-1));
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active_cnt <= CNT_W'(NUM_CS));

endmodule

// File: rtl/dcsw_scan.sv
module dcsw_scan
    import dcsw_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter bit COHERENT = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  cs_win_t [NUM_CS-1:0]      wins,
    input  logic [NUM_CS-1:0]         usable_vec,
    input  logic                      lk_req,
    input  logic [31:0]               lk_addr,
    output logic                      lk_ready,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic [$clog2(NUM_CS)-1:0] res_cs,
    output logic [NUM_CS:0]           res_attr
);
    localparam int CS_W = $clog2(NUM_CS);
    localparam logic [CS_W-1:0] LAST_IDX = CS_W'(NUM_CS - 1);

    function automatic logic [NUM_CS:0] attr_for(logic [CS_W-1:0] idx);
        logic [NUM_CS:0] a;
        a = {COHERENT, {NUM_CS{1'b1}}};
        a[idx] = 1'b0;
        return a;
    endfunction

    scan_state_e     state_q, state_d;
    logic [CS_W-1:0] idx_q;
    logic [7:0]      addr_q;
    logic            hit_q;
    logic [CS_W-1:0] hit_cs_q;
    logic            match_now;

    assign match_now = usable_vec[idx_q] &&
        (((addr_q ^ wins[idx_q].base_top) & ~wins[idx_q].span) == 8'd0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (lk_req) state_d = S_SCAN;
            S_SCAN:  if (idx_q == LAST_IDX) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            addr_q   <= '0;
            hit_q    <= 1'b0;
            hit_cs_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (lk_req) begin
                        addr_q   <= lk_addr[31:24];
                        idx_q    <= '0;
                        hit_q    <= 1'b0;
                        hit_cs_q <= '0;
                    end
                end
                S_SCAN: begin
                    if (match_now && !hit_q) begin
                        hit_q    <= 1'b1;
                        hit_cs_q <= idx_q;
                    end
                    if (idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        lk_ready  = 1'b0;
        res_valid = 1'b0;
        res_hit   = 1'b0;
        res_cs    = '0;
        res_attr  = '0;
        unique case (state_q)
            S_IDLE: lk_ready = 1'b1;
            S_SCAN: ;
            S_DONE: begin
                res_valid = 1'b1;
                res_hit   = hit_q;
                if (hit_q) begin
                    res_cs   = hit_cs_q;
                    res_attr = attr_for(hit_cs_q);
                end
            end
            default: ;
        endcase
    end

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_ready) |=> !lk_ready);
    a_r9_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (lk_ready && !res_valid));
    a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_attr == '0 && res_cs == '0));
    a_r7_hit_attr_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (!res_attr[res_cs] && res_attr[NUM_CS] == COHERENT));

endmodule

// File: rtl/dcsw_window_map.sv
module dcsw_window_map
    import dcsw_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter bit COHERENT = 1'b0,
    localparam int CS_W    = $clog2(NUM_CS),
    localparam int CNT_W   = $clog2(NUM_CS+1),
    localparam int REG_AW  = CS_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_req,
    input  logic [31:0]       lk_addr,
    output logic              lk_ready,
    output logic              res_valid,
    output logic              res_hit,
    output logic [CS_W-1:0]   res_cs,
    output logic [NUM_CS:0]   res_attr,
    output logic [CNT_W-1:0]  active_cnt,
    input  logic [CS_W-1:0]   rd_slot,
    output logic              slot_valid,
    output logic [CS_W-1:0]   slot_cs,
    output logic [31:0]       slot_base,
    output logic [32:0]       slot_size,
    output logic [NUM_CS:0]   slot_attr
);
    cs_win_t [NUM_CS-1:0] wins;
    logic [NUM_CS-1:0]    usable_vec;

    dcsw_regs #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wins      (wins)
    );

    dcsw_compact #(.NUM_CS(NUM_CS), .COHERENT(COHERENT)) u_compact (
        .clk        (clk),
        .rst_n      (rst_n),
        .wins       (wins),
        .rd_slot    (rd_slot),
        .usable_vec (usable_vec),
        .active_cnt (active_cnt),
        .slot_valid (slot_valid),
        .slot_cs    (slot_cs),
        .slot_base  (slot_base),
        .slot_size  (slot_size),
        .slot_attr  (slot_attr)
    );

    dcsw_scan #(.NUM_CS(NUM_CS), .COHERENT(COHERENT)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .wins       (wins),
        .usable_vec (usable_vec),
        .lk_req     (lk_req),
        .lk_addr    (lk_addr),
        .lk_ready   (lk_ready),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_cs     (res_cs),
        .res_attr   (res_attr)
    );

    // R1: the cycle after reset releases, nothing is usable
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active_cnt == '0 && lk_ready));

endmodule

// File: tb/dcsw_window_map_test.sv
module dcsw_window_map_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_ready, res_valid, res_hit;
    logic [1:0]  res_cs;
    logic [4:0]  res_attr;
    logic [2:0]  active_cnt;
    logic [1:0]  rd_slot = '0;
    logic        slot_valid;
    logic [1:0]  slot_cs;
    logic [31:0] slot_base;
    logic [32:0] slot_size;
    logic [4:0]  slot_attr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic       hit;
        logic [1:0] cs;
        logic [4:0] attr;
        int         due;
        string      tag;
    } exp_t;
    exp_t sb[$];

    dcsw_window_map uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
        .lk_addr(lk_addr), .lk_ready(lk_ready), .res_valid(res_valid),
        .res_hit(res_hit), .res_cs(res_cs), .res_attr(res_attr),
        .active_cnt(active_cnt), .rd_slot(rd_slot), .slot_valid(slot_valid),
        .slot_cs(slot_cs), .slot_base(slot_base), .slot_size(slot_size),
        .slot_attr(slot_attr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected result", 64'(res_valid), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " hit"},  64'(res_hit),  64'(e.hit));
                chk({e.tag, " cs"},   64'(res_cs),   64'(e.cs));
                chk({e.tag, " attr"}, 64'(res_attr), 64'(e.attr));
                chk("R9 latency",     64'(cyc),      64'(e.due));
            end
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic slot_chk(string tag, logic [1:0] k, logic v, logic [1:0] cs,
                            logic [31:0] base, logic [32:0] size, logic [4:0] attr);
        rd_slot = k;
        #1;
        chk({tag, " valid"}, 64'(slot_valid), 64'(v));
        if (v) begin
            chk({tag, " cs"},   64'(slot_cs),   64'(cs));
            chk({tag, " base"}, 64'(slot_base), 64'(base));
            chk({tag, " size"}, 64'(slot_size), 64'(size));
            chk({tag, " attr"}, 64'(slot_attr), 64'(attr));
        end
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 20 && sb.size() != 0; i++) @(negedge clk);
        chk("R9 result arrived", 64'(sb.size()), 64'd0);
        @(negedge clk);
    endtask

    // Driver: issue a lookup and push its expectation.
    task automatic lookup(string tag, logic [31:0] a, logic hit, logic [1:0] cs, logic [4:0] attr);
        exp_t e;
        @(negedge clk);
        e.hit = hit; e.cs = cs; e.attr = attr; e.tag = tag;
        e.due = cyc + 1 + NUM_CS;
        sb.push_back(e);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
        wait_drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 active_cnt", 64'(active_cnt), 64'd0);
        chk("R1 lk_ready", 64'(lk_ready), 64'd1);
        for (int i = 0; i < 8; i++) rd_chk("R1 readback zero", 5'(i*4), 32'd0);
        slot_chk("R1 slot0", 2'd0, 1'b0, '0, '0, '0, '0);
        lookup("R1 lookup miss", 32'h0000_0000, 1'b0, 2'd0, 5'h00);

        // R2/R3: program windows and check masked readback
        wr(5'h00, 32'h0012_3450);
        wr(5'h04, 32'h0F00_0F15);
        rd_chk("R3 base mask", 5'h00, 32'h0000_0000);
        rd_chk("R3 size mask and cs tag", 5'h04, 32'h0F00_0015);
        wr(5'h08, 32'h1000_0000);
        wr(5'h0C, 32'h0F00_0001);
        wr(5'h10, 32'h2000_0003);
        wr(5'h14, 32'h1F00_0001);
        wr(5'h18, 32'h4000_0000);
        wr(5'h1C, 32'h3F00_0001);
        rd_chk("R3 base ext kept", 5'h10, 32'h2000_0003);
        rd_chk("R2 cs3 size offset", 5'h1C, 32'h3F00_0001);

        // R4/R5/R6: cs2 excluded by its high base bits
        chk("R5 R4 count with ext bits", 64'(active_cnt), 64'd3);
        slot_chk("R6 slot0", 2'd0, 1'b1, 2'd0, 32'h0000_0000, 33'h0_1000_0000, 5'h0E);
        slot_chk("R6 slot1", 2'd1, 1'b1, 2'd1, 32'h1000_0000, 33'h0_1000_0000, 5'h0D);
        slot_chk("R6 R7 slot2", 2'd2, 1'b1, 2'd3, 32'h4000_0000, 33'h0_4000_0000, 5'h07);
        slot_chk("R6 slot3 empty", 2'd3, 1'b0, '0, '0, '0, '0);

        // R8: decode
        lookup("R8 cs0", 32'h0500_0000, 1'b1, 2'd0, 5'h0E);
        lookup("R8 cs1 top", 32'h1FFF_FFFF, 1'b1, 2'd1, 5'h0D);
        lookup("R4 unusable cs2", 32'h2000_0000, 1'b0, 2'd0, 5'h00);
        lookup("R7 cs3", 32'h7F00_0000, 1'b1, 2'd3, 5'h07);
        lookup("R8 miss high", 32'h8000_0000, 1'b0, 2'd0, 5'h00);
        lookup("R8 miss gap", 32'h3000_0000, 1'b0, 2'd0, 5'h00);

        // R8: overlap, lowest index wins
        wr(5'h08, 32'h0000_0000);
        wr(5'h0C, 32'h1F00_0001);
        lookup("R8 overlap low wins", 32'h0500_0000, 1'b1, 2'd0, 5'h0E);
        lookup("R8 overlap upper", 32'h1500_0000, 1'b1, 2'd1, 5'h0D);

        // R4/R5: disable cs0
        wr(5'h04, 32'h0F00_0000);
        chk("R5 count after disable", 64'(active_cnt), 64'd2);
        slot_chk("R6 slot0 repacked", 2'd0, 1'b1, 2'd1, 32'h0000_0000, 33'h0_2000_0000, 5'h0D);
        lookup("R4 disabled skipped", 32'h0500_0000, 1'b1, 2'd1, 5'h0D);

        // R4: clearing ext bits makes cs2 usable
        wr(5'h10, 32'h2000_0000);
        chk("R5 count after ext clear", 64'(active_cnt), 64'd3);
        slot_chk("R6 slot1 cs2", 2'd1, 1'b1, 2'd2, 32'h2000_0000, 33'h0_2000_0000, 5'h0B);
        lookup("R7 cs2 attr", 32'h2500_0000, 1'b1, 2'd2, 5'h0B);

        // R2: low address bits ignored
        wr(5'h1A, 32'h5000_0000);
        rd_chk("R2 low bits ignored", 5'h18, 32'h5000_0000);
        lookup("R8 cs3 moved", 32'h4500_0000, 1'b1, 2'd3, 5'h07);

        // R9: request while busy is ignored
        begin
            exp_t e;
            @(negedge clk);
            e.hit = 1'b1; e.cs = 2'd1; e.attr = 5'h0D; e.tag = "R9 busy first";
            e.due = cyc + 1 + NUM_CS;
            sb.push_back(e);
            lk_req = 1'b1; lk_addr = 32'h1500_0000;
            @(negedge clk);
            lk_req = 1'b0;
            chk("R9 not ready while busy", 64'(lk_ready), 64'd0);
            lk_req = 1'b1; lk_addr = 32'h2500_0000;
            @(negedge clk);
            lk_req = 1'b0;
            wait_drain();
            repeat (8) @(negedge clk);
            chk("R9 idle again", 64'(lk_ready), 64'd1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule